// File: doc/BRIEF.md
# MDIO Slave with Extended Register Addressing

This block is a management slave on the two-wire MDC/MDIO serial bus. It decodes standard clause-22 frames, but answers only frames whose PHY address lies in the upper half of the address space (16 to 31). The low four PHY address bits and the five register address bits are folded into a 10-bit system address. The lowest register address bit does not select a register. It picks which 16-bit half of a 32-bit system register the frame carries.

Two consecutive frames that target the same 32-bit register with opposite half selects form one atomic 32-bit access on a simple internal register bus. The two halves may arrive in either order.

- **Reads:** the first frame of a pair raises a single read request. It returns the selected half and keeps the other half for the second frame.
- **Writes:** the first half is buffered. One 32-bit write strobe fires only when the matching complementary half arrives.

The whole block runs on MDC. The register bank is expected to return read data combinationally from the address while the read request is high.

Top module: `mgmt_xaddr_slave`

## Requirements
- R1: A frame is recognised only after at least PRE_LEN (default 32) consecutive ones followed by the start pattern 0 then 1. A frame with a shorter preamble or a wrong start pattern raises no bus strobe and never drives MDIO. It also leaves any pending half intact.
- R2: A frame with PHY address 0 to 15 (address MSB clear) is ignored: MDIO stays released and no strobe is raised.
- R3: The bus address is {PHY address bits 3:0, register address bits 4:1, 2'b00}. PHY bits 3:0 land on system bits 9:6, register bits 4:1 on system bits 5:2, and register bit 0 is the half select at system bit 1.
- R4: In a claimed read (opcode 10), MDIO is released for the first turnaround slot and driven 0 in the second. It then carries 16 data bits MSB first and is released again after the last data bit. All output changes are launched on the MDC rising edge.
- R5: Half select 1 carries register bits 31:16, so byte 3 goes out first. Half select 0 carries bits 15:0, so byte 1 goes out first.
- R6: The first read of a pair raises reg_re for exactly one cycle and holds the other half. A complementary second read to the same register raises no reg_re and returns the held half, even if the register changed in between.
- R7: A write pair (opcode 01), in either order, raises exactly one one-cycle reg_we after the second frame's last data bit. The strobe carries the 32-bit combination of both halves at the pair's address. A lone first half writes nothing.
- R8: Any decoded header that does not complete the pending pair discards the pending half. Such a header differs in address or opcode, repeats the same half select, or targets PHY 0 to 15. A claimed header of this kind then starts a new pair.
- R9: A frame with opcode 00 or 11 is ignored: no drive and no strobe.
- R10: While reset is asserted, MDIO output enable, reg_re and reg_we are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; the only clock of the block |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdio_i | input | 1 | Sampled MDIO line level |
| mdio_o | output | 1 | MDIO drive value |
| mdio_oe | output | 1 | MDIO drive enable (1 = slave drives the line) |
| reg_addr | output | 10 | 32-bit-aligned system register address |
| reg_wdata | output | 32 | Combined write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read request |
| reg_rdata | input | 32 | Read data, valid while reg_re is high |

## Verification
A corrupted pending-half record shows up in two ways. A second read returns wrong data on MDIO within the same frame, or raises a superfluous reg_re right after that frame's header. A write pair with a corrupted record raises a missing or spurious reg_we within one cycle after the second frame's last data bit. A receiver state that is off by one slot moves the turnaround zero or the data bits to the wrong slot, so it shows on the first read frame. A wrongly kept or lost pending flag stays invisible until the next frame decides whether it completes a pair.

// File: rtl/mxs_pkg.sv
package mxs_pkg;
   localparam int HALF_W = 16;
   localparam int WORD_W = 32;
   localparam int SYS_AW = 10;
   localparam int PHY_W  = 5;
   localparam int REG_W  = 5;
   localparam int HDR_W  = 2 + PHY_W + REG_W;
   localparam int KEY_W  = SYS_AW - 2;

   typedef enum logic [2:0] {
      RX_HUNT,
      RX_START,
      RX_OPC,
      RX_ADR,
      RX_TURN,
      RX_DATA
   } rx_state_e;

   typedef struct packed {
      logic       rd;
      logic [3:0] phy_lo;
      logic [3:0] reg_hi;
      logic       ws;
   } hdr_t;
endpackage

// File: rtl/mxs_frame_rx.sv
module mxs_frame_rx
   import mxs_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_i,
   output logic              hdr_ev,
   output logic              hdr_claim,
   output hdr_t              hdr_now,
   output logic              ta_ev,
   output logic              last_ev,
   output logic [HALF_W-1:0] half_now
);
   localparam int PC_W  = $clog2(PRE_LEN + 1);
   localparam int BC_W  = $clog2(HALF_W);
   localparam logic [PC_W-1:0] PRE_MAX = PC_W'(PRE_LEN);
   localparam logic [BC_W-1:0] ADR_LAST = BC_W'(PHY_W + REG_W - 1);
   localparam logic [BC_W-1:0] DAT_LAST = BC_W'(HALF_W - 1);

   generate
      if (PRE_LEN < 1 || PRE_LEN > 255) begin : g_bad_pre
         $error("mxs_frame_rx: PRE_LEN out of range");
      end
   endgenerate

   rx_state_e         st_q;
   logic [PC_W-1:0]   pre_q;
   logic [BC_W-1:0]   bc_q;
   logic [HDR_W-2:0]  hsh_q;
   logic [HALF_W-2:0] dsh_q;
   logic [HDR_W-1:0]  hdr_bits;
   logic              op_ok;

   assign hdr_bits  = {hsh_q, bit_i};
   assign op_ok     = (hdr_bits[HDR_W-1 -: 2] == 2'b10) || (hdr_bits[HDR_W-1 -: 2] == 2'b01);
   assign hdr_ev    = (st_q == RX_ADR) && (bc_q == ADR_LAST);
   assign hdr_claim = hdr_ev && hdr_bits[PHY_W+REG_W-1] && op_ok;
   assign hdr_now   = '{rd:     (hdr_bits[HDR_W-1 -: 2] == 2'b10),
                        phy_lo: hdr_bits[8:5],
                        reg_hi: hdr_bits[4:1],
                        ws:     hdr_bits[0]};
   assign ta_ev     = (st_q == RX_TURN) && (bc_q == '0);
   assign last_ev   = (st_q == RX_DATA) && (bc_q == DAT_LAST);
   assign half_now  = {dsh_q, bit_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= RX_HUNT;
         pre_q <= '0;
         bc_q  <= '0;
         hsh_q <= '0;
         dsh_q <= '0;
      end else begin
         unique case (st_q)
            RX_HUNT: begin
               if (bit_i) begin
                  if (pre_q != PRE_MAX) pre_q <= pre_q + PC_W'(1);
               end else begin
                  pre_q <= '0;
                  if (pre_q == PRE_MAX) st_q <= RX_START;
               end
            end
            RX_START: begin
               bc_q <= '0;
               st_q <= bit_i ? RX_OPC : RX_HUNT;
            end
            RX_OPC: begin
               hsh_q <= {hsh_q[HDR_W-3:0], bit_i};
               if (bc_q == BC_W'(1)) begin
                  bc_q <= '0;
                  st_q <= RX_ADR;
               end else begin
                  bc_q <= bc_q + BC_W'(1);
               end
            end
            RX_ADR: begin
               hsh_q <= {hsh_q[HDR_W-3:0], bit_i};
               if (hdr_ev) begin
                  bc_q <= '0;
                  st_q <= hdr_claim ? RX_TURN : RX_HUNT;
               end else begin
                  bc_q <= bc_q + BC_W'(1);
               end
            end
            RX_TURN: begin
               if (bc_q == BC_W'(1)) begin
                  bc_q <= '0;
                  st_q <= RX_DATA;
               end else begin
                  bc_q <= bc_q + BC_W'(1);
               end
            end
            RX_DATA: begin
               dsh_q <= {dsh_q[HALF_W-3:0], bit_i};
               if (last_ev) begin
                  bc_q <= '0;
                  st_q <= RX_HUNT;
               end else begin
                  bc_q <= bc_q + BC_W'(1);
               end
            end
            default: st_q <= RX_HUNT;
         endcase
      end
   end
endmodule

// File: rtl/mxs_pair.sv
module mxs_pair
   import mxs_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hdr_ev,
   input  logic              hdr_claim,
   input  hdr_t              hdr_now,
   input  logic              ta_ev,
   input  logic              last_ev,
   input  logic [HALF_W-1:0] half_now,
   input  logic [WORD_W-1:0] rdata,
   output logic [SYS_AW-1:0] reg_addr,
   output logic              reg_re,
   output logic              reg_we,
   output logic [WORD_W-1:0] reg_wdata,
   output logic              tx_arm,
   output logic [HALF_W-1:0] rd_half
);
   logic              pend_v, pend_rd, pend_need;
   logic [KEY_W-1:0]  pend_key;
   logic [HALF_W-1:0] pend_half;
   logic              cur_rd, cur_ws, cur_match;
   logic [HALF_W-1:0] cur_held;
   logic [SYS_AW-1:0] addr_q;
   logic [KEY_W-1:0]  key_now;
   logic              match;
   logic [HALF_W-1:0] fresh_half, other_half;

   assign key_now    = {hdr_now.phy_lo, hdr_now.reg_hi};
   assign match      = pend_v && hdr_claim && (pend_rd == hdr_now.rd)
                       && (pend_key == key_now) && (pend_need == hdr_now.ws);
   assign tx_arm     = hdr_claim && hdr_now.rd;
   assign fresh_half = cur_ws ? rdata[WORD_W-1:HALF_W] : rdata[HALF_W-1:0];
   assign other_half = cur_ws ? rdata[HALF_W-1:0] : rdata[WORD_W-1:HALF_W];
   assign rd_half    = cur_match ? cur_held : fresh_half;
   assign reg_addr   = addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v    <= 1'b0;
         pend_rd   <= 1'b0;
         pend_need <= 1'b0;
         pend_key  <= '0;
         pend_half <= '0;
         cur_rd    <= 1'b0;
         cur_ws    <= 1'b0;
         cur_match <= 1'b0;
         cur_held  <= '0;
         addr_q    <= '0;
         reg_re    <= 1'b0;
         reg_we    <= 1'b0;
         reg_wdata <= '0;
      end else begin
         reg_re <= 1'b0;
         reg_we <= 1'b0;
         if (hdr_ev) pend_v <= 1'b0;
         if (hdr_claim) begin
            addr_q    <= {key_now, 2'b00};
            cur_rd    <= hdr_now.rd;
            cur_ws    <= hdr_now.ws;
            cur_match <= match;
            if (match && hdr_now.rd) cur_held <= pend_half;
            if (!match && hdr_now.rd) reg_re <= 1'b1;
         end
         if (ta_ev && cur_rd && !cur_match) begin
            pend_v    <= 1'b1;
            pend_rd   <= 1'b1;
            pend_key  <= addr_q[SYS_AW-1:2];
            pend_need <= ~cur_ws;
            pend_half <= other_half;
         end
         if (last_ev && !cur_rd) begin
            if (cur_match) begin
               reg_we    <= 1'b1;
               reg_wdata <= cur_ws ? {half_now, pend_half} : {pend_half, half_now};
            end else begin
               pend_v    <= 1'b1;
               pend_rd   <= 1'b0;
               pend_key  <= addr_q[SYS_AW-1:2];
               pend_need <= ~cur_ws;
               pend_half <= half_now;
            end
         end
      end
   end
endmodule

// File: rtl/mxs_tx.sv
module mxs_tx
   import mxs_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_arm,
   input  logic              ta_ev,
   input  logic [HALF_W-1:0] rd_half,
   output logic              mdio_o,
   output logic              mdio_oe
);
   localparam int CW = $clog2(HALF_W + 1);

   logic              armed_q;
   logic [HALF_W-1:0] sh_q;
   logic [CW-1:0]     cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         mdio_oe <= 1'b0;
         mdio_o  <= 1'b0;
         sh_q    <= '0;
         cnt_q   <= '0;
      end else begin
         if (tx_arm) armed_q <= 1'b1;
         if (ta_ev && armed_q) begin
            armed_q <= 1'b0;
            mdio_oe <= 1'b1;
            mdio_o  <= 1'b0;
            sh_q    <= rd_half;
            cnt_q   <= CW'(HALF_W);
         end else if (mdio_oe) begin
            if (cnt_q != '0) begin
               mdio_o <= sh_q[HALF_W-1];
               sh_q   <= {sh_q[HALF_W-2:0], 1'b0};
               cnt_q  <= cnt_q - CW'(1);
            end else begin
               mdio_oe <= 1'b0;
               mdio_o  <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/mgmt_xaddr_slave.sv
module mgmt_xaddr_slave
   import mxs_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic        mdc,
   input  logic        rst_n,
   input  logic        mdio_i,
   output logic        mdio_o,
   output logic        mdio_oe,
   output logic [9:0]  reg_addr,
   output logic [31:0] reg_wdata,
   output logic        reg_we,
   output logic        reg_re,
   input  logic [31:0] reg_rdata
);
   logic              hdr_ev, hdr_claim, ta_ev, last_ev, tx_arm;
   hdr_t              hdr_now;
   logic [HALF_W-1:0] half_now, rd_half;

   mxs_frame_rx #(.PRE_LEN(PRE_LEN)) u_rx (
      .clk       (mdc),
      .rst_n     (rst_n),
      .bit_i     (mdio_i),
      .hdr_ev    (hdr_ev),
      .hdr_claim (hdr_claim),
      .hdr_now   (hdr_now),
      .ta_ev     (ta_ev),
      .last_ev   (last_ev),
      .half_now  (half_now)
   );

   mxs_pair u_pair (
      .clk       (mdc),
      .rst_n     (rst_n),
      .hdr_ev    (hdr_ev),
      .hdr_claim (hdr_claim),
      .hdr_now   (hdr_now),
      .ta_ev     (ta_ev),
      .last_ev   (last_ev),
      .half_now  (half_now),
      .rdata     (reg_rdata),
      .reg_addr  (reg_addr),
      .reg_re    (reg_re),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .tx_arm    (tx_arm),
      .rd_half   (rd_half)
   );

   mxs_tx u_tx (
      .clk     (mdc),
      .rst_n   (rst_n),
      .tx_arm  (tx_arm),
      .ta_ev   (ta_ev),
      .rd_half (rd_half),
      .mdio_o  (mdio_o),
      .mdio_oe (mdio_oe)
   );
endmodule

// File: rtl/mxs_chk.sv
module mxs_chk (
   input logic       mdc,
   input logic       rst_n,
   input logic       mdio_o,
   input logic       mdio_oe,
   input logic       reg_re,
   input logic       reg_we,
   input logic [9:0] reg_addr
);
   logic [4:0] oe_run;

   always_ff @(posedge mdc or negedge rst_n) begin
      if (!rst_n) oe_run <= '0;
      else if (mdio_oe) oe_run <= oe_run + 5'd1;
      else oe_run <= '0;
   end

   // R4
   ta_zero_chk: assert property (@(posedge mdc) disable iff (!rst_n)
      $rose(mdio_oe) |-> !mdio_o);

   // R4
   drive_len_chk: assert property (@(posedge mdc) disable iff (!rst_n)
      $fell(mdio_oe) |-> (oe_run == 5'd17));

   // R4
   drive_max_chk: assert property (@(posedge mdc) disable iff (!rst_n)
      mdio_oe |-> (oe_run < 5'd17));

   // R6
   re_pulse_chk: assert property (@(posedge mdc) disable iff (!rst_n)
      reg_re |=> !reg_re);

   // R7
   we_pulse_chk: assert property (@(posedge mdc) disable iff (!rst_n)
      reg_we |=> !reg_we);

   // R7
   we_addr_chk: assert property (@(posedge mdc) disable iff (!rst_n)
      $rose(reg_we) |-> $stable(reg_addr));
endmodule

bind mgmt_xaddr_slave mxs_chk u_chk (
   .mdc      (mdc),
   .rst_n    (rst_n),
   .mdio_o   (mdio_o),
   .mdio_oe  (mdio_oe),
   .reg_re   (reg_re),
   .reg_we   (reg_we),
   .reg_addr (reg_addr)
);

// File: tb/mgmt_xaddr_slave_bench.sv
module mgmt_xaddr_slave_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic        mdio_m;
   logic        mdio_line;
   logic        mdio_o, mdio_oe;
   logic [9:0]  reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic        reg_we, reg_re;

   logic [31:0] bank [0:1023];
   logic        poke_en;
   logic [9:0]  poke_addr;
   logic [31:0] poke_data;

   assign mdio_line = mdio_oe ? mdio_o : mdio_m;
   assign reg_rdata = bank[reg_addr];

   always @(posedge clk) begin
      if (reg_we) bank[reg_addr] <= reg_wdata;
      if (poke_en) bank[poke_addr] <= poke_data;
   end

   mgmt_xaddr_slave u_mgmt_xaddr_slave (
      .mdc       (clk),
      .rst_n     (rst_n),
      .mdio_i    (mdio_line),
      .mdio_o    (mdio_o),
      .mdio_oe   (mdio_oe),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_we    (reg_we),
      .reg_re    (reg_re),
      .reg_rdata (reg_rdata)
   );

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;
   int re_cnt = 0;
   int we_cnt = 0;
   logic [9:0]  re_addr, we_addr;
   logic [31:0] we_data;

   always @(negedge clk) begin
      if (rst_n) begin
         if (reg_re) begin re_cnt++; re_addr = reg_addr; end
         if (reg_we) begin we_cnt++; we_addr = reg_addr; we_data = reg_wdata; end
      end
   end

   // behavioural model of the pending half
   bit          m_v = 1'b0;
   bit          m_rd, m_need;
   logic [7:0]  m_key;
   logic [15:0] m_half;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic poke(input logic [9:0] a, input logic [31:0] d);
      @(negedge clk);
      poke_en = 1'b1; poke_addr = a; poke_data = d;
      @(negedge clk);
      poke_en = 1'b0;
   endtask

   task automatic frame(input int pre, input logic [1:0] stb, input logic [1:0] op,
                        input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] wd, input string tag);
      logic        bits[$];
      bit          hit, claim, rd, match, exp_re, exp_we;
      logic [9:0]  addr;
      logic [31:0] word, exp_wd;
      logic [15:0] half;
      int          g, re0, we0;
      hit   = (pre >= 32) && (stb == 2'b01);
      claim = hit && phy[4] && (op == 2'b10 || op == 2'b01);
      rd    = (op == 2'b10);
      addr  = {phy[3:0], rg[4:1], 2'b00};
      match = m_v && claim && (m_rd == rd) && (m_key == addr[9:2]) && (m_need == rg[0]);
      exp_re = 1'b0; exp_we = 1'b0; half = '0; exp_wd = '0; word = '0;
      if (claim && rd) begin
         if (match) half = m_half;
         else begin
            word = bank[addr];
            half = rg[0] ? word[31:16] : word[15:0];
            exp_re = 1'b1;
         end
      end
      if (claim && !rd && match) begin
         exp_we = 1'b1;
         exp_wd = rg[0] ? {wd, m_half} : {m_half, wd};
      end
      if (hit) m_v = 1'b0;
      if (claim && !match) begin
         m_v = 1'b1; m_rd = rd; m_key = addr[9:2]; m_need = ~rg[0];
         m_half = rd ? (rg[0] ? word[15:0] : word[31:16]) : wd;
      end
      bits.push_back(1'b0);
      for (int i = 0; i < pre; i++) bits.push_back(1'b1);
      bits.push_back(stb[1]); bits.push_back(stb[0]);
      bits.push_back(op[1]);  bits.push_back(op[0]);
      for (int i = 4; i >= 0; i--) bits.push_back(phy[i]);
      for (int i = 4; i >= 0; i--) bits.push_back(rg[i]);
      bits.push_back(1'b1); bits.push_back(rd ? 1'b1 : 1'b0);
      for (int i = 15; i >= 0; i--) bits.push_back(rd ? 1'b1 : wd[i]);
      bits.push_back(1'b0); bits.push_back(1'b0);
      g = 1 + pre;
      re0 = re_cnt; we0 = we_cnt;
      foreach (bits[i]) begin
         int   j;
         logic eoe, eo;
         @(negedge clk);
         j = i - g; eoe = 1'b0; eo = 1'b0;
         if (claim && rd) begin
            if (j == 15) eoe = 1'b1;
            if (j >= 16 && j <= 31) begin eoe = 1'b1; eo = half[31-j]; end
         end
         chk({tag, " mdio_oe"}, {31'd0, mdio_oe}, {31'd0, eoe});
         if (eoe) chk({tag, " mdio_o"}, {31'd0, mdio_o}, {31'd0, eo});
         mdio_m = bits[i];
      end
      @(negedge clk);
      chk({tag, " reg_re count"}, re_cnt - re0, {31'd0, exp_re});
      if (exp_re) chk({tag, " R3 read address"}, {22'd0, re_addr}, {22'd0, addr});
      chk({tag, " reg_we count"}, we_cnt - we0, {31'd0, exp_we});
      if (exp_we) begin
         chk({tag, " R3 write address"}, {22'd0, we_addr}, {22'd0, addr});
         chk({tag, " write data"}, we_data, exp_wd);
      end
   endtask

   task automatic report;
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      mdio_m = 1'b0; poke_en = 1'b0; poke_addr = '0; poke_data = '0;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10 oe in reset", {31'd0, mdio_oe}, 32'd0);
      chk("R10 re in reset", {31'd0, reg_re}, 32'd0);
      chk("R10 we in reset", {31'd0, reg_we}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 oe after reset", {31'd0, mdio_oe}, 32'd0);
      poke(10'h04C, 32'hA1B2_C3D4);
      poke(10'h3E8, 32'h5566_7788);
      poke(10'h100, 32'h0000_0000);

      // R6 R5 R3: low half first, register changes before the second half
      frame(32, 2'b01, 2'b10, 5'd17, 5'd6, 16'h0, "R6 first read lo");
      poke(10'h04C, 32'hDEAD_BEEF);
      frame(32, 2'b01, 2'b10, 5'd17, 5'd7, 16'h0, "R6 second read hi held");
      // R5: high half first
      frame(32, 2'b01, 2'b10, 5'd31, 5'd21, 16'h0, "R5 read hi first");
      frame(32, 2'b01, 2'b10, 5'd31, 5'd20, 16'h0, "R5 read lo second");
      // R7: write hi then lo, then read back
      frame(32, 2'b01, 2'b01, 5'd20, 5'd1, 16'h1234, "R7 write hi first");
      frame(32, 2'b01, 2'b01, 5'd20, 5'd0, 16'h5678, "R7 write lo completes");
      frame(32, 2'b01, 2'b10, 5'd20, 5'd0, 16'h0, "R5 readback lo");
      frame(32, 2'b01, 2'b10, 5'd20, 5'd1, 16'h0, "R5 readback hi");
      // R7: write lo then hi
      frame(32, 2'b01, 2'b01, 5'd20, 5'd0, 16'hAAAA, "R7 write lo first");
      frame(32, 2'b01, 2'b01, 5'd20, 5'd1, 16'hBBBB, "R7 write hi completes");
      // R8: same half select twice
      frame(32, 2'b01, 2'b01, 5'd20, 5'd0, 16'h1111, "R8 write lo");
      frame(32, 2'b01, 2'b01, 5'd20, 5'd0, 16'h2222, "R8 repeated lo restarts");
      frame(32, 2'b01, 2'b01, 5'd20, 5'd1, 16'h3333, "R8 hi pairs with newer lo");
      // R8 R2: intervening low-PHY frame
      frame(32, 2'b01, 2'b01, 5'd20, 5'd0, 16'h4444, "R8 write lo before low phy");
      frame(32, 2'b01, 2'b10, 5'd5, 5'd1, 16'h0, "R2 low phy read ignored");
      frame(32, 2'b01, 2'b01, 5'd20, 5'd1, 16'h5555, "R8 hi after low phy unpaired");
      frame(32, 2'b01, 2'b01, 5'd20, 5'd0, 16'h6666, "R8 lo completes new pair");
      // R8: different address, then opcode mismatch
      frame(32, 2'b01, 2'b10, 5'd17, 5'd6, 16'h0, "R8 read A lo");
      frame(32, 2'b01, 2'b10, 5'd31, 5'd21, 16'h0, "R8 read B hi new pair");
      frame(32, 2'b01, 2'b01, 5'd20, 5'd0, 16'h7777, "R8 write lo");
      frame(32, 2'b01, 2'b10, 5'd20, 5'd1, 16'h0, "R8 read hi opcode mismatch");
      // R1: short preamble and bad start keep the pending half
      frame(32, 2'b01, 2'b01, 5'd20, 5'd0, 16'h9999, "R1 write lo pending");
      frame(31, 2'b01, 2'b01, 5'd20, 5'd1, 16'h0F0F, "R1 short preamble ignored");
      frame(32, 2'b00, 2'b10, 5'd20, 5'd1, 16'h0, "R1 bad start ignored");
      frame(32, 2'b01, 2'b01, 5'd20, 5'd1, 16'h8888, "R1 pending survived");
      frame(31, 2'b01, 2'b10, 5'd17, 5'd6, 16'h0, "R1 short preamble read");
      // R9: illegal opcodes
      frame(32, 2'b01, 2'b11, 5'd17, 5'd6, 16'hFFFF, "R9 opcode 11");
      frame(32, 2'b01, 2'b00, 5'd17, 5'd7, 16'h0000, "R9 opcode 00");
      repeat (4) @(negedge clk);
      report();
   end
endmodule